// File: doc/BRIEF.md
# Host Register File with Split Resets

This block is a small bank of 16-bit configuration registers that a host reads and writes over a simple synchronous word bus. The bus has a word address, a write/read select, write data, registered read data and per-byte enables. Every access moves a whole word. The byte enables only decide whether a transaction happens at all.

Two reset sources act on the bank, and they reach different amounts of state. The hardware reset pin clears the master register, the bridge-mode register, the general configuration registers and the read path. A software reset is started by writing 1 to bit 0 of the master register. It lasts one clock and clears the same state, except that the bridge-mode register keeps its value. A separate group of reset-exempt registers is cleared by neither reset, so the host must load it after power-up.

After either reset, a port-ready flag stays low for a delay of `READY_US` microseconds. The delay is converted into `READY_CYC = CLK_KHZ*READY_US/1000` clock cycles. With the defaults of 64000 kHz and 625 us, this gives 40000 cycles.

Top module: `hostreg_bank`

## Requirements
- R1: When `bus_be` is non-zero, a write stores all 16 bits of `bus_wdata`, and a read returns the whole word. Which bits of `bus_be` are set makes no difference.
- R2: When `bus_be` is 2'b00, no transaction occurs. No register is written, and `bus_rdata` keeps its previous value.
- R3: Read data is registered. The word addressed at the clock edge that samples a read appears on `bus_rdata` after that edge. It stays there until the next read or reset, even if the register is written in the meantime.
- R4: The address map is: 0 = master register, 1 = bridge-mode register, 2..5 = configuration registers 0..3, and 6..9 = reset-exempt registers 0..3. A read of any address from 10 to 15 returns 16'h0000.
- R5: If `srst` is high at a clock edge, the master, bridge-mode and configuration registers and `bus_rdata` are 0 after that edge. `port_ready` is also 0 after that edge. A bus access sampled in that cycle is dropped.
- R6: Writing a word with bit 0 = 1 to address 0 produces a one-cycle internal reset in the following cycle. That reset clears the master and configuration registers and `bus_rdata`, and restarts the ready delay. A bus access in the reset cycle is dropped, and the internal reset does not repeat.
- R7: The bridge-mode register (address 1) keeps its value through the software reset. Only `srst` clears it.
- R8: The reset-exempt registers (addresses 6..9) keep their contents through both `srst` and the software reset.
- R9: `port_ready` is low after any reset. It rises exactly `READY_CYC` clock edges after the last edge at which a reset was applied. It then stays high until the next reset.
- R10: Bits 15:1 of the master register have no meaning. Writes to them are ignored, they read back as 0, and writing 0 to bit 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| srst | input | 1 | Hardware reset, synchronous, active high |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | DATA_W/8 | Byte enables; any set bit starts a transaction |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| port_ready | output | 1 | High once the post-reset delay has elapsed |

## Verification
Faults in this block show up at the ports within one or two cycles, apart from the ready delay. A master bit stuck high would clear everything again on the very next edge. A bridge register that is wrongly reached by the software reset reads back as zero on the first read after the pulse. A reset-exempt word that is wrongly cleared also reads back wrong on its first read. A ready counter that starts at the wrong point or counts wrongly makes `port_ready` rise early or late, so the bench measures the edge count from each kind of reset and compares `bus_rdata` and `port_ready` against a behavioural model on every clock.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  // Fixed word positions; the configuration and reset-exempt groups follow them.
  localparam int MASTER_ADDR = 0;
  localparam int BRIDGE_ADDR = 1;
  localparam int CFG_BASE    = 2;

  // Bit of the master register that starts a software reset.
  localparam int SWRST_BIT = 0;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_MASTER,
    RG_BRIDGE,
    RG_CFG,
    RG_KEEP
  } region_e;

endpackage

// File: rtl/hostreg_decode.sv
module hostreg_decode
  import hostreg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_CFG  = 4,
  parameter int NUM_KEEP = 4,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam int CFG_END   = CFG_BASE + NUM_CFG;
  localparam int KEEP_BASE = CFG_END;
  localparam int KEEP_END  = KEEP_BASE + NUM_KEEP;

  logic [31:0] a_w;

  always_comb begin
    a_w    = 32'(addr);
    region = RG_NONE;
    idx    = '0;
    if (a_w == 32'(MASTER_ADDR)) begin
      region = RG_MASTER;
    end else if (a_w == 32'(BRIDGE_ADDR)) begin
      region = RG_BRIDGE;
    end else if (a_w >= 32'(CFG_BASE) && a_w < 32'(CFG_END)) begin
      region = RG_CFG;
      idx    = IDX_W'(a_w - 32'(CFG_BASE));
    end else if (a_w >= 32'(KEEP_BASE) && a_w < 32'(KEEP_END)) begin
      region = RG_KEEP;
      idx    = IDX_W'(a_w - 32'(KEEP_BASE));
    end
  end

endmodule

// File: rtl/hostreg_cfg_bank.sv
module hostreg_cfg_bank #(
  parameter int NUM    = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM-1:0][DATA_W-1:0] regs
);

  // One resettable word per configuration slot; every write loads the full word.
  for (genvar g = 0; g < NUM; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (clr) begin
        regs[g] <= '0;
      end else if (we && (32'(idx) == g)) begin
        regs[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/hostreg_keep_ram.sv
module hostreg_keep_ram #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  // No reset on purpose: this storage survives both reset sources and maps to block RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/hostreg_ready_timer.sv
module hostreg_ready_timer #(
  parameter int CYCLES = 40000
) (
  input  logic clk,
  input  logic clr,
  output logic ready
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(CYCLES - 1)) begin
        ready <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank
  import hostreg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NUM_CFG  = 4,
  parameter int NUM_KEEP = 4,
  parameter int CLK_KHZ  = 64000,
  parameter int READY_US = 625
) (
  input  logic                clk,
  input  logic                srst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                port_ready
);

  localparam int BE_W      = DATA_W / 8;
  localparam int IDX_MAX   = (NUM_CFG > NUM_KEEP) ? NUM_CFG : NUM_KEEP;
  localparam int IDX_W     = (IDX_MAX > 1) ? $clog2(IDX_MAX) : 1;
  localparam int KEEP_END  = CFG_BASE + NUM_CFG + NUM_KEEP;
  localparam int READY_CYC = (CLK_KHZ * READY_US) / 1000;

  region_e                    region;
  logic [IDX_W-1:0]           idx;
  logic                       any_be;
  logic                       sw_pulse;
  logic                       clr_all;
  logic                       wr_ok;
  logic                       rd_ok;
  logic [DATA_W-1:0]          bridge_q;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_regs;
  logic [DATA_W-1:0]          ram_q;
  logic [DATA_W-1:0]          rd_word_q;
  logic                       rd_from_ram;

  hostreg_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_CFG (NUM_CFG),
    .NUM_KEEP(NUM_KEEP),
    .IDX_W   (IDX_W)
  ) i_decode (
    .addr  (bus_addr),
    .region(region),
    .idx   (idx)
  );

  // Any set byte enable makes a full-word transaction; none is accepted while a reset acts.
  assign any_be  = |bus_be;
  assign clr_all = srst | sw_pulse;
  assign wr_ok   = any_be & bus_we & ~clr_all;
  assign rd_ok   = any_be & ~bus_we & ~clr_all;

  // The master bit is itself cleared by the reset it starts, so the pulse is one cycle long.
  always_ff @(posedge clk) begin
    if (clr_all) begin
      sw_pulse <= 1'b0;
    end else if (wr_ok && region == RG_MASTER) begin
      sw_pulse <= bus_wdata[SWRST_BIT];
    end
  end

  // Bridge-mode word: only the hardware pin reaches it.
  always_ff @(posedge clk) begin
    if (srst) begin
      bridge_q <= '0;
    end else if (wr_ok && region == RG_BRIDGE) begin
      bridge_q <= bus_wdata;
    end
  end

  hostreg_cfg_bank #(
    .NUM   (NUM_CFG),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) i_cfg (
    .clk  (clk),
    .clr  (clr_all),
    .we   (wr_ok && region == RG_CFG),
    .idx  (idx),
    .wdata(bus_wdata),
    .regs (cfg_regs)
  );

  hostreg_keep_ram #(
    .DEPTH (NUM_KEEP),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) i_keep (
    .clk  (clk),
    .we   (wr_ok && region == RG_KEEP),
    .waddr(idx),
    .wdata(bus_wdata),
    .re   (rd_ok && region == RG_KEEP),
    .raddr(idx),
    .rdata(ram_q)
  );

  // Read capture for the resettable words; the RAM keeps its own output register.
  always_ff @(posedge clk) begin
    if (clr_all) begin
      rd_word_q   <= '0;
      rd_from_ram <= 1'b0;
    end else if (rd_ok) begin
      rd_from_ram <= (region == RG_KEEP);
      unique case (region)
        RG_MASTER: rd_word_q <= {{(DATA_W-1){1'b0}}, sw_pulse};
        RG_BRIDGE: rd_word_q <= bridge_q;
        RG_CFG:    rd_word_q <= cfg_regs[idx];
        default:   rd_word_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_from_ram ? ram_q : rd_word_q;

  hostreg_ready_timer #(
    .CYCLES(READY_CYC)
  ) i_timer (
    .clk  (clk),
    .clr  (clr_all),
    .ready(port_ready)
  );

endmodule

// File: rtl/hostreg_bank_chk.sv
module hostreg_bank_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int BE_W      = 2,
  parameter int MAP_END   = 10,
  parameter int READY_CYC = 40000
) (
  input logic              clk,
  input logic              srst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BE_W-1:0]   bus_be,
  input logic              wdata_b0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              port_ready,
  input logic              sw_pulse,
  input logic [DATA_W-1:0] bridge_q
);

  localparam int CW = $clog2(READY_CYC + 2);

  // Independent count of edges since the last reset of either kind.
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (srst || sw_pulse) begin
      since_rst <= '0;
    end else if (since_rst != CW'(READY_CYC + 1)) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (bus_be == '0 && !sw_pulse) |=> $stable(bus_rdata));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (srst)
    ((|bus_be) && !bus_we && !sw_pulse && 32'(bus_addr) >= MAP_END) |=> (bus_rdata == '0));

  // R5
  hw_reset_clear_chk: assert property (@(posedge clk) disable iff (srst)
    $fell(srst) |-> (bus_rdata == '0 && !port_ready && bridge_q == '0));

  // R6
  sw_trigger_chk: assert property (@(posedge clk) disable iff (srst)
    ((|bus_be) && bus_we && bus_addr == '0 && wdata_b0 && !sw_pulse) |=> sw_pulse);

  // R6
  sw_single_pulse_chk: assert property (@(posedge clk) disable iff (srst)
    sw_pulse |=> (!sw_pulse && !port_ready && bus_rdata == '0));

  // R7
  bridge_survives_chk: assert property (@(posedge clk) disable iff (srst)
    sw_pulse |=> $stable(bridge_q));

  // R9
  ready_early_chk: assert property (@(posedge clk) disable iff (srst)
    (since_rst < CW'(READY_CYC)) |-> !port_ready);

  // R9
  ready_late_chk: assert property (@(posedge clk) disable iff (srst)
    (since_rst >= CW'(READY_CYC)) |-> port_ready);

endmodule

bind hostreg_bank hostreg_bank_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BE_W     (BE_W),
  .MAP_END  (KEEP_END),
  .READY_CYC(READY_CYC)
) i_chk (
  .clk       (clk),
  .srst      (srst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_be    (bus_be),
  .wdata_b0  (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .port_ready(port_ready),
  .sw_pulse  (sw_pulse),
  .bridge_q  (bridge_q)
);

// File: tb/test_hostreg_bank.sv
module test_hostreg_bank;

  localparam int CLK_KHZ  = 100000;
  localparam int READY_US = 1;
  localparam int N_RDY    = (CLK_KHZ * READY_US) / 1000;

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        port_ready;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hostreg_bank #(
    .CLK_KHZ (CLK_KHZ),
    .READY_US(READY_US)
  ) i_hostreg_bank (
    .clk       (clk),
    .srst      (srst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_ready(port_ready)
  );

  // Behavioural reference model.
  logic [15:0] m_bridge = '0;
  logic [15:0] m_cfg [4];
  logic [15:0] m_keep [4];
  logic [15:0] m_rd = '0;
  logic        m_swp = 1'b0;
  int          m_cnt = 0;

  function automatic logic [15:0] m_look(input int a);
    if (a == 1) return m_bridge;
    if (a >= 2 && a < 6) return m_cfg[a-2];
    if (a >= 6 && a < 10) return m_keep[a-6];
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    int a;
    a = int'(bus_addr);
    if (srst || m_swp) begin
      if (srst) m_bridge = '0;
      m_swp = 1'b0;
      for (int i = 0; i < 4; i++) m_cfg[i] = '0;
      m_rd  = '0;
      m_cnt = 0;
    end else begin
      if (bus_be != 2'b00 && bus_we) begin
        if (a == 0) m_swp = bus_wdata[0];
        else if (a == 1) m_bridge = bus_wdata;
        else if (a >= 2 && a < 6) m_cfg[a-2] = bus_wdata;
        else if (a >= 6 && a < 10) m_keep[a-6] = bus_wdata;
      end else if (bus_be != 2'b00) begin
        m_rd = m_look(a);
      end
      if (m_cnt < N_RDY) m_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R3 read path, R9 ready flag).
  always @(negedge clk) begin
    if (chk_on) begin
      check(bus_rdata === m_rd, "R3 rdata vs model", bus_rdata, m_rd);
      check(port_ready === (m_cnt >= N_RDY), "R9 ready vs model",
            16'(port_ready), 16'(m_cnt >= N_RDY));
    end
  end

  task automatic cyc(input logic [3:0] a, input logic w, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_be = b; bus_wdata = d;
  endtask

  task automatic idle();
    cyc(4'd0, 1'b0, 2'b00, 16'h0000);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [1:0] b, input logic [15:0] exp, input string req);
    cyc(a, 1'b0, b, 16'h0000);
    idle();
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  // Called at the first negedge after the last reset edge.
  task automatic ready_wait(input string req);
    int k;
    k = 0;
    while (!port_ready && k < 4 * N_RDY) begin
      @(negedge clk);
      k++;
    end
    check(k == N_RDY, req, 16'(k), 16'(N_RDY));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    chk_on = 1'b1;
    // R5: reset state
    check(bus_rdata === 16'h0000, "R5 rdata after hw reset", bus_rdata, 16'h0000);
    check(port_ready === 1'b0, "R5 ready low after hw reset", 16'(port_ready), 16'h0000);
    ready_wait("R9 ready delay after power-up reset");

    // R8: load reset-exempt words
    cyc(4'd6, 1'b1, 2'b11, 16'h1111);
    cyc(4'd7, 1'b1, 2'b01, 16'h2222);
    cyc(4'd8, 1'b1, 2'b10, 16'h3333);
    cyc(4'd9, 1'b1, 2'b11, 16'hC0DE);
    // R1: writes with differing byte enables store whole words
    cyc(4'd1, 1'b1, 2'b01, 16'hA5C3);
    cyc(4'd2, 1'b1, 2'b10, 16'hBEEF);
    cyc(4'd3, 1'b1, 2'b11, 16'h0F0F);
    cyc(4'd5, 1'b1, 2'b01, 16'h8001);
    rd_chk(4'd1, 2'b10, 16'hA5C3, "R1 bridge full word via upper lane");
    rd_chk(4'd2, 2'b01, 16'hBEEF, "R1 cfg0 full word via lower lane");
    rd_chk(4'd5, 2'b11, 16'h8001, "R4 cfg3 at address 5");
    rd_chk(4'd9, 2'b01, 16'hC0DE, "R4 keep3 at address 9");

    // R3: read held after register is rewritten
    cyc(4'd3, 1'b0, 2'b01, 16'h0000);
    cyc(4'd3, 1'b1, 2'b11, 16'h7777);
    idle();
    check(bus_rdata === 16'h0F0F, "R3 read data held after rewrite", bus_rdata, 16'h0F0F);

    // R2: no byte enable means no read and no write
    cyc(4'd1, 1'b0, 2'b00, 16'h0000);
    idle();
    check(bus_rdata === 16'h0F0F, "R2 read without enables ignored", bus_rdata, 16'h0F0F);
    cyc(4'd2, 1'b1, 2'b00, 16'h5555);
    rd_chk(4'd2, 2'b11, 16'hBEEF, "R2 write without enables ignored");

    // R4: unmapped addresses
    rd_chk(4'd12, 2'b01, 16'h0000, "R4 unmapped address 12");
    rd_chk(4'd3, 2'b11, 16'h7777, "R1 cfg1 rewrite visible");
    rd_chk(4'd15, 2'b10, 16'h0000, "R4 unmapped address 15");

    // R10: meaningless master bits
    cyc(4'd0, 1'b1, 2'b11, 16'hFFFE);
    rd_chk(4'd0, 2'b11, 16'h0000, "R10 master spare bits read zero");
    check(port_ready === 1'b1, "R10 no reset from bit0=0 write", 16'(port_ready), 16'h0001);

    // R6: software reset; write in the pulse cycle is dropped
    cyc(4'd0, 1'b1, 2'b01, 16'h0001);
    cyc(4'd2, 1'b1, 2'b11, 16'h1234);
    idle();
    check(bus_rdata === 16'h0000, "R6 rdata cleared by sw reset", bus_rdata, 16'h0000);
    check(port_ready === 1'b0, "R6 ready low after sw reset", 16'(port_ready), 16'h0000);
    ready_wait("R9 ready delay after sw reset");
    rd_chk(4'd2, 2'b11, 16'h0000, "R6 cfg0 cleared and pulse-cycle write dropped");
    rd_chk(4'd3, 2'b01, 16'h0000, "R6 cfg1 cleared");
    rd_chk(4'd1, 2'b11, 16'hA5C3, "R7 bridge survives sw reset");
    rd_chk(4'd7, 2'b11, 16'h2222, "R8 keep1 survives sw reset");

    // R5: hardware reset
    cyc(4'd4, 1'b1, 2'b11, 16'h4444);
    @(negedge clk);
    srst = 1'b1;
    bus_be = 2'b00;
    @(negedge clk);
    srst = 1'b0;
    check(bus_rdata === 16'h0000, "R5 rdata cleared by hw reset", bus_rdata, 16'h0000);
    ready_wait("R9 ready delay after hw reset");
    rd_chk(4'd1, 2'b11, 16'h0000, "R5 bridge cleared by hw reset");
    rd_chk(4'd4, 2'b11, 16'h0000, "R5 cfg2 cleared by hw reset");
    rd_chk(4'd6, 2'b10, 16'h1111, "R8 keep0 survives hw reset");
    rd_chk(4'd8, 2'b01, 16'h3333, "R8 keep2 survives hw reset");

    repeat (3) idle();
    done = 1'b1;
    finish_run();
  end

endmodule